// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page translations. Each entry holds a virtual page number, a physical page frame, a translation granule of 4 KB, 16 KB or 64 KB, and a set of memory properties: a 3-bit attribute index, a 2-bit access-permission field, separate unprivileged and privileged execute-never bits, and an access flag. Each entry also carries context tags. It is bound either to one address-space identifier or marked global. An entry filled for the guest EL1&0 regime also stores a virtual-machine identifier.

A lookup presents a virtual address, the current address-space identifier, the current virtual-machine identifier and a regime flag. The result comes back one cycle later. When the context changes, stale entries stay in the array and simply stop matching, so nothing has to be flushed. A fill port loads new entries. Three invalidate commands remove entries: everything, everything for one address space, or everything for one virtual machine. Walking page tables, raising faults and combining second-stage attributes are handled elsewhere.

Top module: `tagged_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` and `rsp_hit` are 0, and every lookup misses until a fill.
- R2: A lookup issued with `lk_req` high in one cycle returns `rsp_valid` high in the next cycle. `rsp_valid` is low in a cycle that follows no request.
- R3: A non-global entry matches only when its stored address-space identifier equals `lk_asid`. A global entry (`fill_global`=1) matches for any `lk_asid`. Entries of other contexts stay resident and hit again when their context returns.
- R4: An entry filled with `fill_guest`=1 matches only lookups with `lk_guest`=1 and an equal `lk_vmid`. An entry filled with `fill_guest`=0 matches only lookups with `lk_guest`=0, whatever `lk_vmid` is.
- R5: The granule code is 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, and 3 is treated as 4 KB. The compare covers VA bits 47 down to 12, 14 or 16 respectively. On a hit, `rsp_pa` is the entry's frame above that boundary with the lookup VA bits below it.
- R6: On a hit, `rsp_attr`, `rsp_perm`, `rsp_uxn` and `rsp_pxn` equal the values filled. On a miss they are 0.
- R7: `rsp_af` returns the entry's access flag as stored before the lookup. When `hw_af_en` is 1, a hit sets that flag to 1. When `hw_af_en` is 0, the flag is unchanged.
- R8: A fill writes the lowest-index invalid entry. When all entries are valid, it replaces the entry named by a round-robin pointer that starts at 0 and advances by one on each replacement.
- R9: `inv_all` clears every entry in one cycle.
- R10: `inv_asid_en` clears exactly the non-global entries whose identifier equals `inv_asid`. Global entries survive.
- R11: `inv_vmid_en` clears exactly the guest-regime entries whose identifier equals `inv_vmid`.
- R12: When several entries match, the lowest-index one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space identifier |
| lk_vmid | input | 16 | Current virtual-machine identifier |
| lk_guest | input | 1 | 1 = guest EL1&0 regime lookup |
| hw_af_en | input | 1 | Enable hardware setting of the access flag |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 36 | Virtual page number (VA bits 47:12) |
| fill_ppn | input | 28 | Physical frame (PA bits 39:12) |
| fill_gran | input | 2 | Granule code |
| fill_asid | input | 16 | Address-space identifier of the entry |
| fill_global | input | 1 | Entry matches any address space |
| fill_guest | input | 1 | Entry belongs to the guest regime |
| fill_vmid | input | 16 | Virtual-machine identifier of the entry |
| fill_attr | input | 3 | Attribute index |
| fill_perm | input | 2 | Access permissions |
| fill_uxn | input | 1 | Unprivileged execute-never |
| fill_pxn | input | 1 | Privileged execute-never |
| fill_af | input | 1 | Initial access flag |
| inv_all | input | 1 | Invalidate all entries |
| inv_asid_en | input | 1 | Invalidate by address space |
| inv_asid | input | 16 | Address space to invalidate |
| inv_vmid_en | input | 1 | Invalidate by virtual machine |
| inv_vmid | input | 16 | Virtual machine to invalidate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 40 | Physical address |
| rsp_attr | output | 3 | Attribute index |
| rsp_perm | output | 2 | Access permissions |
| rsp_uxn | output | 1 | Unprivileged execute-never |
| rsp_pxn | output | 1 | Privileged execute-never |
| rsp_af | output | 1 | Access flag before this lookup |

## Verification
Directed sequences probe one qualifier at a time. The same page is looked up under a foreign address space, a foreign virtual machine and the wrong regime, so a miss can be traced to a single tag. Lookups with offsets that vary inside the 16 KB and 64 KB windows show whether the granule masks the compare and builds the address correctly. Duplicate fills separate lowest-index priority from arbitrary selection, and a full array of nine or ten fills exposes the replacement order. A seeded random mix of fills, lookups and the three invalidates over small pools of pages and identifiers then forces frequent context collisions, with each response compared against a reference model kept in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int MAX_SHIFT  = 16;
  localparam int EXT_W      = MAX_SHIFT - PAGE_SHIFT;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_64K = 2'd2,
    GRAN_RSV = 2'd3
  } gran_e;

  // Bits of VA[15:12] that take part in the compare (1 = compared, frame bit used)
  function automatic logic [EXT_W-1:0] keep_mask(input logic [1:0] g);
    case (gran_e'(g))
      GRAN_16K: keep_mask = 4'b1100;
      GRAN_64K: keep_mask = 4'b0000;
      default:  keep_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match #(
  parameter int VPN_W  = 36,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16
) (
  input  logic              e_valid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [1:0]        e_gran,
  input  logic              e_glob,
  input  logic              e_guest,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_guest,
  output logic              hit_o
);
  import tlb_pkg::*;

  logic hi_eq, lo_eq, asid_ok, vmid_ok;

  always_comb begin
    hi_eq   = (e_vpn[VPN_W-1:EXT_W] == lk_vpn[VPN_W-1:EXT_W]);
    lo_eq   = (((e_vpn[EXT_W-1:0] ^ lk_vpn[EXT_W-1:0]) & keep_mask(e_gran)) == '0);
    asid_ok = e_glob || (e_asid == lk_asid);
    vmid_ok = (e_guest == lk_guest) && (!e_guest || (e_vmid == lk_vmid));
    hit_o   = e_valid && hi_eq && lo_eq && asid_ok && vmid_ok;
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    victim_o = free_found ? free_idx : rr_q;
    rr_d     = rr_q;
    if (alloc_i && !free_found) begin
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc_i) begin
      rr_q <= rr_d;
    end
  end

  AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !(&valid_i)) |-> !valid_i[victim_o]); // R8
  AST_RR_HOLDS_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !(&valid_i)) |=> $stable(rr_q)); // R8
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int NUM_ENT = 8,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 16,
  parameter int ATTR_W  = 3,
  parameter int PERM_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_req,
  input  logic [VA_W-1:0]              lk_va,
  input  logic [ASID_W-1:0]            lk_asid,
  input  logic [VMID_W-1:0]            lk_vmid,
  input  logic                         lk_guest,
  input  logic                         hw_af_en,
  input  logic                         fill_en,
  input  logic [VA_W-tlb_pkg::PAGE_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-tlb_pkg::PAGE_SHIFT-1:0] fill_ppn,
  input  logic [1:0]                   fill_gran,
  input  logic [ASID_W-1:0]            fill_asid,
  input  logic                         fill_global,
  input  logic                         fill_guest,
  input  logic [VMID_W-1:0]            fill_vmid,
  input  logic [ATTR_W-1:0]            fill_attr,
  input  logic [PERM_W-1:0]            fill_perm,
  input  logic                         fill_uxn,
  input  logic                         fill_pxn,
  input  logic                         fill_af,
  input  logic                         inv_all,
  input  logic                         inv_asid_en,
  input  logic [ASID_W-1:0]            inv_asid,
  input  logic                         inv_vmid_en,
  input  logic [VMID_W-1:0]            inv_vmid,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [PA_W-1:0]              rsp_pa,
  output logic [ATTR_W-1:0]            rsp_attr,
  output logic [PERM_W-1:0]            rsp_perm,
  output logic                         rsp_uxn,
  output logic                         rsp_pxn,
  output logic                         rsp_af
);
  import tlb_pkg::*;

  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PPN_W = PA_W - PAGE_SHIFT;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  // Entry storage
  logic [NUM_ENT-1:0] valid_q, valid_d;
  logic [NUM_ENT-1:0] af_q, af_d;
  logic [VPN_W-1:0]   vpn_q   [NUM_ENT];
  logic [PPN_W-1:0]   ppn_q   [NUM_ENT];
  logic [1:0]         gran_q  [NUM_ENT];
  logic               glob_q  [NUM_ENT];
  logic               guest_q [NUM_ENT];
  logic [ASID_W-1:0]  asid_q  [NUM_ENT];
  logic [VMID_W-1:0]  vmid_q  [NUM_ENT];
  logic [ATTR_W-1:0]  attr_q  [NUM_ENT];
  logic [PERM_W-1:0]  perm_q  [NUM_ENT];
  logic               uxn_q   [NUM_ENT];
  logic               pxn_q   [NUM_ENT];

  logic [NUM_ENT-1:0] hit_vec;
  logic [IDX_W-1:0]   victim;
  logic [VPN_W-1:0]   lk_vpn;

  assign lk_vpn = lk_va[VA_W-1:PAGE_SHIFT];

  tlb_victim_sel #(.N(NUM_ENT), .IDX_W(IDX_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_ns),
    .valid_i  (valid_q),
    .alloc_i  (fill_en),
    .victim_o (victim)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic wr_en;
    assign wr_en = fill_en && (victim == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (wr_en) begin
        vpn_q[g]   <= fill_vpn;
        ppn_q[g]   <= fill_ppn;
        gran_q[g]  <= fill_gran;
        glob_q[g]  <= fill_global;
        guest_q[g] <= fill_guest;
        asid_q[g]  <= fill_asid;
        vmid_q[g]  <= fill_vmid;
        attr_q[g]  <= fill_attr;
        perm_q[g]  <= fill_perm;
        uxn_q[g]   <= fill_uxn;
        pxn_q[g]   <= fill_pxn;
      end
    end

    tlb_entry_match #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_match (
      .e_valid  (valid_q[g]),
      .e_vpn    (vpn_q[g]),
      .e_gran   (gran_q[g]),
      .e_glob   (glob_q[g]),
      .e_guest  (guest_q[g]),
      .e_asid   (asid_q[g]),
      .e_vmid   (vmid_q[g]),
      .lk_vpn   (lk_vpn),
      .lk_asid  (lk_asid),
      .lk_vmid  (lk_vmid),
      .lk_guest (lk_guest),
      .hit_o    (hit_vec[g])
    );
  end

  // Select the lowest-index match and build the response
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [PA_W-1:0]  pa_c;
  logic [EXT_W-1:0] mid_c;
  logic [EXT_W-1:0] km_c;
  logic [PPN_W-1:0] sel_ppn;

  always_comb begin
    hit_any = |hit_vec;
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    sel_ppn = ppn_q[hit_idx];
    km_c    = keep_mask(gran_q[hit_idx]);
    for (int b = 0; b < EXT_W; b++) begin
      mid_c[b] = km_c[b] ? sel_ppn[b] : lk_va[PAGE_SHIFT+b];
    end
    pa_c = {sel_ppn[PPN_W-1:EXT_W], mid_c, lk_va[PAGE_SHIFT-1:0]};
  end

  // Next state of valid and access-flag vectors
  always_comb begin
    valid_d = valid_q;
    af_d    = af_q;
    if (lk_req && hit_any && hw_af_en) af_d[hit_idx] = 1'b1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (inv_all) valid_d[i] = 1'b0;
      if (inv_asid_en && !glob_q[i] && (asid_q[i] == inv_asid)) valid_d[i] = 1'b0;
      if (inv_vmid_en && guest_q[i] && (vmid_q[i] == inv_vmid)) valid_d[i] = 1'b0;
    end
    if (fill_en) begin
      valid_d[victim] = 1'b1;
      af_d[victim]    = fill_af;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      valid_q <= '0;
      af_q    <= '0;
    end else begin
      valid_q <= valid_d;
      af_q    <= af_d;
    end
  end

  // Registered response
  logic take;
  assign take = lk_req && hit_any;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
      rsp_perm  <= '0;
      rsp_uxn   <= 1'b0;
      rsp_pxn   <= 1'b0;
      rsp_af    <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= take;
      rsp_pa    <= take ? pa_c : '0;
      rsp_attr  <= take ? attr_q[hit_idx] : '0;
      rsp_perm  <= take ? perm_q[hit_idx] : '0;
      rsp_uxn   <= take ? uxn_q[hit_idx] : 1'b0;
      rsp_pxn   <= take ? pxn_q[hit_idx] : 1'b0;
      rsp_af    <= take ? af_q[hit_idx] : 1'b0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    lk_req |=> rsp_valid); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_hit |-> rsp_valid); // R2
  AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (rsp_valid && !rsp_hit) |-> (rsp_attr == '0 && rsp_perm == '0 && !rsp_uxn && !rsp_pxn)); // R6
  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ns)
    (inv_all && !fill_en) |=> (valid_q == '0)); // R9
  AST_AF_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_ns)
    (lk_req && hw_af_en && hit_any && !fill_en) |=> af_q[$past(hit_idx)]); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_ns)
    fill_en |=> valid_q[$past(victim)]); // R8
endmodule

// File: tb/tagged_tlb_tb_top.sv
`timescale 1ns/1ps
module tagged_tlb_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_guest, hw_af_en;
  logic [47:0] lk_va;
  logic [15:0] lk_asid, lk_vmid;
  logic        fill_en, fill_global, fill_guest, fill_uxn, fill_pxn, fill_af;
  logic [35:0] fill_vpn;
  logic [27:0] fill_ppn;
  logic [1:0]  fill_gran, fill_perm;
  logic [15:0] fill_asid, fill_vmid, inv_asid, inv_vmid;
  logic [2:0]  fill_attr;
  logic        inv_all, inv_asid_en, inv_vmid_en;
  logic        rsp_valid, rsp_hit, rsp_uxn, rsp_pxn, rsp_af;
  logic [39:0] rsp_pa;
  logic [2:0]  rsp_attr;
  logic [1:0]  rsp_perm;

  always #2.5 clk = ~clk;

  tagged_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
    .lk_guest(lk_guest), .hw_af_en(hw_af_en),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_gran(fill_gran),
    .fill_asid(fill_asid), .fill_global(fill_global), .fill_guest(fill_guest),
    .fill_vmid(fill_vmid), .fill_attr(fill_attr), .fill_perm(fill_perm),
    .fill_uxn(fill_uxn), .fill_pxn(fill_pxn), .fill_af(fill_af),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
    .inv_vmid_en(inv_vmid_en), .inv_vmid(inv_vmid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
    .rsp_perm(rsp_perm), .rsp_uxn(rsp_uxn), .rsp_pxn(rsp_pxn), .rsp_af(rsp_af)
  );

  // Reference model
  bit          m_v     [N];
  logic [35:0] m_vpn   [N];
  logic [27:0] m_ppn   [N];
  logic [1:0]  m_gran  [N];
  bit          m_glob  [N];
  bit          m_guest [N];
  logic [15:0] m_asid  [N];
  logic [15:0] m_vmid  [N];
  logic [2:0]  m_attr  [N];
  logic [1:0]  m_perm  [N];
  bit          m_uxn   [N];
  bit          m_pxn   [N];
  bit          m_af    [N];
  int          m_rr;

  int n_chk  = 0;
  int n_fail = 0;

  function automatic int shift_of(logic [1:0] g);
    if (g == 2'd1) return 14;
    if (g == 2'd2) return 16;
    return 12;
  endfunction

  function automatic int m_find(logic [47:0] va, logic [15:0] a, logic [15:0] v, bit gst);
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && (m_guest[i] == gst) && (!gst || m_vmid[i] == v) &&
          (m_glob[i] || m_asid[i] == a) &&
          ((va >> shift_of(m_gran[i])) == ({m_vpn[i], 12'h000} >> shift_of(m_gran[i]))))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [39:0] m_pa(int i, logic [47:0] va);
    logic [39:0] full, lowm;
    full = {m_ppn[i], 12'h000};
    lowm = (40'd1 << shift_of(m_gran[i])) - 40'd1;
    return (full & ~lowm) | (va[39:0] & lowm);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [47:0] va, input logic [15:0] a, input logic [15:0] v,
                           input bit gst, input bit hwaf, input string req, input int exp_hit);
    int i;
    i = m_find(va, a, v, gst);
    lk_req = 1'b1; lk_va = va; lk_asid = a; lk_vmid = v; lk_guest = gst; hw_af_en = hwaf;
    @(negedge clk);
    lk_req = 1'b0; hw_af_en = 1'b0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "rsp_hit model", 64'(rsp_hit), 64'(i >= 0));
    if (exp_hit >= 0) chk(req, "rsp_hit directed", 64'(rsp_hit), 64'(exp_hit));
    if (i >= 0) begin
      chk(req, "rsp_pa", 64'(rsp_pa), 64'(m_pa(i, va)));
      chk("R6", "rsp_attr", 64'(rsp_attr), 64'(m_attr[i]));
      chk("R6", "rsp_perm", 64'(rsp_perm), 64'(m_perm[i]));
      chk("R6", "xn bits", 64'({rsp_uxn, rsp_pxn}), 64'({m_uxn[i], m_pxn[i]}));
      chk("R7", "rsp_af", 64'(rsp_af), 64'(m_af[i]));
      if (hwaf) m_af[i] = 1'b1;
    end else begin
      chk("R6", "miss fields zero", 64'({rsp_attr, rsp_perm, rsp_uxn, rsp_pxn}), 64'd0);
    end
  endtask

  task automatic do_fill(input logic [47:0] va, input logic [39:0] pa, input logic [1:0] g,
                         input logic [15:0] a, input bit glob, input bit gst, input logic [15:0] v,
                         input logic [2:0] at, input logic [1:0] pm, input bit ux, input bit px,
                         input bit af);
    int vi;
    vi = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vi = i;
    if (vi < 0) begin
      vi = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    fill_en = 1'b1; fill_vpn = va[47:12]; fill_ppn = pa[39:12]; fill_gran = g;
    fill_asid = a; fill_global = glob; fill_guest = gst; fill_vmid = v;
    fill_attr = at; fill_perm = pm; fill_uxn = ux; fill_pxn = px; fill_af = af;
    @(negedge clk);
    fill_en = 1'b0;
    m_v[vi] = 1'b1; m_vpn[vi] = va[47:12]; m_ppn[vi] = pa[39:12]; m_gran[vi] = g;
    m_asid[vi] = a; m_glob[vi] = glob; m_guest[vi] = gst; m_vmid[vi] = v;
    m_attr[vi] = at; m_perm[vi] = pm; m_uxn[vi] = ux; m_pxn[vi] = px; m_af[vi] = af;
  endtask

  // kind: 0 = all, 1 = by address space, 2 = by virtual machine
  task automatic do_inv(input int kind, input logic [15:0] a, input logic [15:0] v);
    inv_all = (kind == 0); inv_asid_en = (kind == 1); inv_vmid_en = (kind == 2);
    inv_asid = a; inv_vmid = v;
    @(negedge clk);
    inv_all = 1'b0; inv_asid_en = 1'b0; inv_vmid_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (kind == 0) m_v[i] = 1'b0;
      if (kind == 1 && !m_glob[i] && m_asid[i] == a) m_v[i] = 1'b0;
      if (kind == 2 && m_guest[i] && m_vmid[i] == v) m_v[i] = 1'b0;
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [47:0] rnd_va();
    return {28'h0, 4'($urandom_range(0, 7)), 16'($urandom)};
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
    rst_n = 1'b0;
    lk_req = 0; lk_va = 0; lk_asid = 0; lk_vmid = 0; lk_guest = 0; hw_af_en = 0;
    fill_en = 0; fill_vpn = 0; fill_ppn = 0; fill_gran = 0; fill_asid = 0;
    fill_global = 0; fill_guest = 0; fill_vmid = 0; fill_attr = 0; fill_perm = 0;
    fill_uxn = 0; fill_pxn = 0; fill_af = 0;
    inv_all = 0; inv_asid_en = 0; inv_asid = 0; inv_vmid_en = 0; inv_vmid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1", "rsp_hit after reset", 64'(rsp_hit), 64'd0);
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b0, "R1", 0);
    idle_check();

    // R3: address-space tagging (entry 0 non-global, entry 1 global)
    do_fill(48'h0000_1234_5000, 40'h00_ABCD_E000, 2'd0, 16'd5, 1'b0, 1'b0, 16'd0, 3'd3, 2'd2, 1'b1, 1'b0, 1'b0);
    do_lookup(48'h0000_1234_5678, 16'd5, 16'd0, 1'b0, 1'b0, "R3", 1);
    chk("R5", "4K pa literal", 64'(rsp_pa), 64'h00_ABCD_E678);
    do_lookup(48'h0000_1234_5678, 16'd6, 16'd0, 1'b0, 1'b0, "R3", 0);
    do_fill(48'h0000_2222_0000, 40'h00_3333_3000, 2'd0, 16'd1, 1'b1, 1'b0, 16'd0, 3'd5, 2'd1, 1'b0, 1'b1, 1'b1);
    do_lookup(48'h0000_2222_0ABC, 16'd9, 16'd7, 1'b0, 1'b0, "R3", 1);
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b0, "R3", 1);

    // R4: guest regime tagging (entry 2)
    do_fill(48'h0000_4444_4000, 40'h00_5555_5000, 2'd0, 16'd1, 1'b0, 1'b1, 16'd2, 3'd6, 2'd3, 1'b1, 1'b1, 1'b0);
    do_lookup(48'h0000_4444_4010, 16'd1, 16'd2, 1'b1, 1'b0, "R4", 1);
    do_lookup(48'h0000_4444_4010, 16'd1, 16'd3, 1'b1, 1'b0, "R4", 0);
    do_lookup(48'h0000_4444_4010, 16'd1, 16'd2, 1'b0, 1'b0, "R4", 0);
    do_lookup(48'h0000_2222_0000, 16'd1, 16'd2, 1'b1, 1'b0, "R4", 0);
    do_lookup(48'h0000_4444_4010, 16'd1, 16'd2, 1'b1, 1'b0, "R4", 1);

    // R5: granules (entry 3 = 64K, entry 4 = 16K)
    do_fill(48'h0000_00AB_0000, 40'h12_3456_7000, 2'd2, 16'd0, 1'b1, 1'b0, 16'd0, 3'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    do_lookup(48'h0000_00AB_F123, 16'd0, 16'd0, 1'b0, 1'b0, "R5", 1);
    chk("R5", "64K pa literal", 64'(rsp_pa), 64'h12_3456_F123);
    do_lookup(48'h0000_00AC_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R5", 0);
    do_fill(48'h0000_0066_4000, 40'h00_7777_B000, 2'd1, 16'd0, 1'b1, 1'b0, 16'd0, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    do_lookup(48'h0000_0066_7FFF, 16'd0, 16'd0, 1'b0, 1'b0, "R5", 1);
    chk("R5", "16K pa literal", 64'(rsp_pa), 64'h00_7777_BFFF);
    do_lookup(48'h0000_0066_8000, 16'd0, 16'd0, 1'b0, 1'b0, "R5", 0);

    // R7: access flag on entry 0
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b0, "R7", 1);
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b1, "R7", 1);
    chk("R7", "af before hw update", 64'(rsp_af), 64'd0);
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b0, "R7", 1);
    chk("R7", "af after hw update", 64'(rsp_af), 64'd1);

    // R12: duplicate mappings at entries 5 and 6
    do_fill(48'h0000_0777_7000, 40'h00_0100_0000, 2'd0, 16'd0, 1'b1, 1'b0, 16'd0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    do_fill(48'h0000_0777_7000, 40'h00_0200_0000, 2'd0, 16'd0, 1'b1, 1'b0, 16'd0, 3'd6, 2'd3, 1'b1, 1'b1, 1'b1);
    do_lookup(48'h0000_0777_7004, 16'd3, 16'd0, 1'b0, 1'b0, "R12", 1);
    chk("R12", "lowest index attr", 64'(rsp_attr), 64'd1);

    // R10, R11, R9: invalidates
    do_inv(1, 16'd5, 16'd0);
    do_lookup(48'h0000_1234_5000, 16'd5, 16'd0, 1'b0, 1'b0, "R10", 0);
    do_lookup(48'h0000_2222_0000, 16'd5, 16'd0, 1'b0, 1'b0, "R10", 1);
    do_inv(2, 16'd0, 16'd2);
    do_lookup(48'h0000_4444_4000, 16'd1, 16'd2, 1'b1, 1'b0, "R11", 0);
    do_lookup(48'h0000_00AB_0000, 16'd0, 16'd2, 1'b0, 1'b0, "R11", 1);
    do_inv(0, 16'd0, 16'd0);
    do_lookup(48'h0000_2222_0000, 16'd1, 16'd0, 1'b0, 1'b0, "R9", 0);
    do_lookup(48'h0000_0777_7000, 16'd1, 16'd0, 1'b0, 1'b0, "R9", 0);

    // R8: fill order and round-robin replacement
    for (int p = 0; p < 9; p++)
      do_fill(48'h0000_0100_0000 + (48'(p) << 16), 40'h00_0900_0000 + (40'(p) << 12),
              2'd0, 16'd0, 1'b1, 1'b0, 16'd0, 3'(p), 2'd0, 1'b0, 1'b0, 1'b1);
    do_lookup(48'h0000_0100_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R8", 0);
    do_lookup(48'h0000_0101_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R8", 1);
    do_lookup(48'h0000_0108_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R8", 1);
    do_fill(48'h0000_0109_0000, 40'h00_0A00_0000, 2'd0, 16'd0, 1'b1, 1'b0, 16'd0, 3'd7, 2'd0, 1'b0, 1'b0, 1'b1);
    do_lookup(48'h0000_0101_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R8", 0);
    do_lookup(48'h0000_0102_0000, 16'd0, 16'd0, 1'b0, 1'b0, "R8", 1);
    do_inv(0, 16'd0, 16'd0);

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45)
        do_lookup(rnd_va(), 16'($urandom_range(0, 3)), 16'($urandom_range(0, 2)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R5", -1);
      else if (r < 75)
        do_fill(rnd_va(), {12'h0, 28'($urandom)}, 2'($urandom_range(0, 3)),
                16'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                16'($urandom_range(0, 2)), 3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom));
      else if (r < 83)
        do_inv(1, 16'($urandom_range(0, 3)), 16'd0);
      else if (r < 90)
        do_inv(2, 16'd0, 16'($urandom_range(0, 2)));
      else if (r < 92)
        do_inv(0, 16'd0, 16'd0);
      else
        idle_check();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule